// File: doc/BRIEF.md
# Direction-Aware GPIO Port Data Register

This block holds the output latch of a 26-position general-purpose I/O port. Software reaches it through a small memory-mapped request/response bus. Each pin has a direction select that marks it as a general output or a general input. An output pin drives its latch bit. An input pin leaves the latch bit stored but undriven. When software reads the data register, each bit is chosen by that pin's direction: the stored latch bit for an output pin, and the synchronized pad level for an input pin. A second, read-only view returns the synchronized pad levels for every pin, whatever the direction.

The 26 positions are split across two 16-bit halves that share one 32-bit word. The upper half holds pins 25..16 in its low ten bits. The lower half holds pins 13..11 and 9..0. Bit positions 10, 14 and 15 have no pin. The latch loads its initial value only on power-on reset. A manual reset clears the bus response stage and the input synchronizers but leaves the latch alone.

Requests use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and is held until `rsp_ready` is seen high. `req_ready` is low while a response waits unaccepted and while manual reset is asserted, so the requester must hold its request until it is taken.

Top module: `gpio_port_regs`

## Requirements
- R1: A write taken at the data register changes `pin_out` on the following cycle. `pin_oe` equals `pin_dir` on every implemented position (1 = output).
- R2: A data-register read returns the latch bit for each pin whose `pin_dir` is 1, whatever the level on `pin_in`.
- R3: A data-register read returns the pad level for each pin whose `pin_dir` is 0. `pin_in` passes through a two-flop synchronizer: a level set just before clock edge E1 is seen by a read taken at edge E3 but not by reads taken at E1 or E2.
- R4: A write to an input pin still updates its latch bit. The pin stays undriven (`pin_oe` 0), and the new value is seen on `pin_out` and in reads once the pin is an output.
- R5: Power-on reset (`por_n` low) loads the latch with `LATCH_INIT` (default all zero). Manual reset (`mrst_n` low) leaves the latch and `pin_out` unchanged, clears `rsp_valid` and holds `req_ready` low.
- R6: The port view at byte offsets 0x1C..0x1F returns the synchronized `pin_in` levels for every pin, whatever the direction. Writes to it are ignored.
- R7: Word layout: bits 25..16 hold pins 25..16, bits 15..0 hold pins 15..0, and bits 31..26, 15, 14 and 10 are unimplemented. Unimplemented bits read 0, ignore writes and have `pin_out` and `pin_oe` 0.
- R8: Offsets are big-endian within the word: 0x00 is the upper half and 0x02 the lower half of the data register. Byte offset k selects word bits [31-8k -: 8]. `req_size` is 0 for byte, 1 for halfword and 2 for word. Write data and read data are right-aligned. A byte or halfword write changes only the addressed lanes.
- R9: An access is illegal if it is misaligned (halfword at an odd offset, word at an offset not a multiple of 4), has `req_size` 3, or falls outside offsets 0x00..0x03 and 0x1C..0x1F. A word access at 0x02 or 0x1E counts as misaligned. An illegal access is still answered, reads 0 and does not change the latch.
- R10: Every request taken gets exactly one response on the next cycle. A write's response carries `rsp_rdata` 0. While `rsp_valid` is high and `rsp_ready` is low, the response and its data stay stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, asynchronous, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Right-aligned read data |
| pin_dir | input | 26 | Per-pin direction, 1 = general output |
| pin_in | input | 26 | Pad levels |
| pin_out | output | 26 | Latch value presented to the pads |
| pin_oe | output | 26 | Per-pin output enable |

## Verification
The hardest case to reach is the synchronizer window: a read has to land exactly one and two edges after a pad level changes and see the old value, then see the new one on the third edge. The bench sets the pad level on a falling edge and issues three back-to-back reads, each taken on consecutive rising edges. Manual reset is hard to tell apart from power-on reset, because both look idle at the ports. The bench loads a distinctive latch pattern, attempts a write during manual reset, and then reads the pattern back intact before pulsing power-on reset.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 5;
  localparam int LANES = BUS_W / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [ADDR_W-1:0] OFF_DATA = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_PORT = 5'h1C;

  typedef struct packed {
    logic             legal;
    logic             sel_data;
    logic             sel_port;
    logic [LANES-1:0] lane_en;
    logic [BUS_W-1:0] wdata_al;
  } dec_t;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [BUS_W-1:0]  wdata,
  output dec_t              dec
);
  logic [ADDR_W-1:0] word_base;
  logic              aligned;

  always_comb begin
    dec       = '0;
    word_base = {addr[ADDR_W-1:2], 2'b00};
    aligned   = 1'b0;
    dec.sel_data = (word_base == OFF_DATA);
    dec.sel_port = (word_base == OFF_PORT);
    case (size)
      SZ_BYTE: begin
        aligned      = 1'b1;
        dec.lane_en  = 4'b0001 << (~addr[1:0]);
        dec.wdata_al = {4{wdata[7:0]}};
      end
      SZ_HALF: begin
        aligned      = ~addr[0];
        dec.lane_en  = addr[1] ? 4'b0011 : 4'b1100;
        dec.wdata_al = {2{wdata[15:0]}};
      end
      SZ_WORD: begin
        aligned      = (addr[1:0] == 2'b00);
        dec.lane_en  = 4'b1111;
        dec.wdata_al = wdata;
      end
      default: aligned = 1'b0;
    endcase
    dec.legal = aligned && (dec.sel_data || dec.sel_port);
    if (!dec.legal) dec.lane_en = '0;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      q      <= '0;
      warm_q <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q == $past(d, 2))); // R3
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch
  import gpio_port_pkg::*;
#(
  parameter int           W    = 26,
  parameter logic [W-1:0] IMPL = 26'h3FF3BFF,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_en,
  input  logic [BUS_W-1:0] wdata,
  output logic [W-1:0]     q
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                     bit_q <= INIT[i];
        else if (wr_en && lane_en[i/8]) bit_q <= wdata[i];
      end
      assign q[i] = bit_q;
    end else begin : g_hole
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int           W    = 26,
  parameter logic [W-1:0] IMPL = 26'h3FF3BFF
) (
  input  logic [W-1:0]     dir,
  input  logic [W-1:0]     latch,
  input  logic [W-1:0]     pins,
  output logic [BUS_W-1:0] data_view,
  output logic [BUS_W-1:0] port_view
);
  logic [W-1:0] dv;
  logic [W-1:0] pv;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign dv[i] = IMPL[i] & (dir[i] ? latch[i] : pins[i]);
    assign pv[i] = IMPL[i] & pins[i];
  end

  assign data_view = {{(BUS_W-W){1'b0}}, dv};
  assign port_view = {{(BUS_W-W){1'b0}}, pv};
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int              PIN_W      = 26,
  parameter logic [PIN_W-1:0] IMPL_MASK  = 26'h3FF3BFF,
  parameter logic [PIN_W-1:0] LATCH_INIT = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic [PIN_W-1:0]  pin_dir,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic              rst_any_n;
  logic              acc_fire;
  logic              latch_wr;
  dec_t              dec;
  logic [PIN_W-1:0]  latch_q;
  logic [PIN_W-1:0]  pins_sync;
  logic [BUS_W-1:0]  data_view;
  logic [BUS_W-1:0]  port_view;
  logic [BUS_W-1:0]  word_sel;
  logic [BUS_W-1:0]  rd_val;

  assign rst_any_n = por_n & mrst_n;
  assign req_ready = mrst_n & (~rsp_valid | rsp_ready);
  assign acc_fire  = req_valid & req_ready;

  gpio_bus_decode u_dec (
    .addr  (req_addr),
    .size  (req_size),
    .wdata (req_wdata),
    .dec   (dec)
  );

  gpio_sync #(.W(PIN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_any_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  assign latch_wr = acc_fire & req_write & dec.legal & dec.sel_data;

  gpio_data_latch #(.W(PIN_W), .IMPL(IMPL_MASK), .INIT(LATCH_INIT)) u_latch (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (latch_wr),
    .lane_en (dec.lane_en),
    .wdata   (dec.wdata_al),
    .q       (latch_q)
  );

  gpio_read_mux #(.W(PIN_W), .IMPL(IMPL_MASK)) u_rmux (
    .dir       (pin_dir),
    .latch     (latch_q),
    .pins      (pins_sync),
    .data_view (data_view),
    .port_view (port_view)
  );

  always_comb begin
    word_sel = dec.sel_port ? port_view : data_view;
    case (req_size)
      SZ_BYTE: rd_val = (word_sel >> {~req_addr[1:0], 3'b000}) & 32'h0000_00FF;
      SZ_HALF: rd_val = req_addr[1] ? {16'h0, word_sel[15:0]} : {16'h0, word_sel[31:16]};
      default: rd_val = word_sel;
    endcase
    if (!dec.legal || req_write) rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign pin_out = latch_q & IMPL_MASK;
  assign pin_oe  = pin_dir & IMPL_MASK;

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_any_n)
    acc_fire |=> rsp_valid); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_any_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
  AST_MRST_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!por_n)
    !mrst_n |=> $stable(pin_out)); // R5
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    (acc_fire && req_write && !dec.legal) |=> $stable(pin_out)); // R9
  AST_PORT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (acc_fire && req_write && dec.sel_port) |=> $stable(pin_out)); // R6
endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
  localparam logic [25:0] AO = 26'h3FF_FFFF;
  localparam logic [25:0] AI = 26'h0;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [25:0] dir;
    logic [25:0] pins;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'h00, 2'd2, 32'hFFFF_FFFF, AO, 26'h0,       32'h0,         8'd1}, // R1 fill latch
    '{1'b0, 5'h00, 2'd2, 32'h0,         AO, 26'h0,       32'h03FF_3BFF, 8'd2}, // R2 R7
    '{1'b0, 5'h00, 2'd2, 32'h0,         AI, 26'h0,       32'h0,         8'd3}, // R3
    '{1'b0, 5'h00, 2'd2, 32'h0,         AI, 26'h2AA_AAAA, 32'h02AA_2AAA, 8'd3}, // R3
    '{1'b0, 5'h02, 2'd1, 32'h0,         26'h0FF, 26'h0,  32'h0000_00FF, 8'd2}, // R2 mixed
    '{1'b1, 5'h03, 2'd0, 32'h5A,        AO, 26'h0,       32'h0,         8'd8}, // R8 byte write
    '{1'b0, 5'h02, 2'd1, 32'h0,         AO, AO,          32'h0000_3B5A, 8'd8}, // R8
    '{1'b1, 5'h00, 2'd0, 32'hFF,        AO, 26'h0,       32'h0,         8'd7}, // R7 hole byte
    '{1'b1, 5'h00, 2'd1, 32'h0123,      AO, 26'h0,       32'h0,         8'd8}, // R8 half write
    '{1'b0, 5'h00, 2'd2, 32'h0,         AO, 26'h0,       32'h0123_3B5A, 8'd8}, // R8
    '{1'b0, 5'h01, 2'd0, 32'h0,         AO, 26'h0,       32'h0000_0023, 8'd8}, // R8
    '{1'b0, 5'h00, 2'd0, 32'h0,         AO, 26'h0,       32'h0000_0001, 8'd8}, // R8
    '{1'b0, 5'h1C, 2'd2, 32'h0,         AO, AO,          32'h03FF_3BFF, 8'd6}, // R6
    '{1'b0, 5'h1E, 2'd1, 32'h0,         AI, 26'h155,     32'h0000_0155, 8'd6}, // R6
    '{1'b1, 5'h1C, 2'd2, 32'h0,         AO, 26'h0,       32'h0,         8'd6}, // R6 write ignored
    '{1'b0, 5'h00, 2'd2, 32'h0,         AO, 26'h0,       32'h0123_3B5A, 8'd6}, // R6
    '{1'b0, 5'h02, 2'd2, 32'h0,         AO, 26'h0,       32'h0,         8'd9}, // R9 word at 0x02
    '{1'b1, 5'h02, 2'd2, 32'h0,         AO, 26'h0,       32'h0,         8'd9}, // R9
    '{1'b0, 5'h02, 2'd1, 32'h0,         AO, 26'h0,       32'h0000_3B5A, 8'd9}, // R9
    '{1'b0, 5'h10, 2'd1, 32'h0,         AO, 26'h0,       32'h0,         8'd9}, // R9 unmapped
    '{1'b1, 5'h01, 2'd1, 32'h0,         AO, 26'h0,       32'h0,         8'd9}, // R9 odd half
    '{1'b0, 5'h00, 2'd2, 32'h0,         AO, 26'h0,       32'h0123_3B5A, 8'd9}, // R9
    '{1'b1, 5'h00, 2'd2, 32'h0,         AI, AO,          32'h0,         8'd4}, // R4
    '{1'b0, 5'h00, 2'd2, 32'h0,         AI, AO,          32'h03FF_3BFF, 8'd4}, // R4
    '{1'b0, 5'h00, 2'd2, 32'h0,         AO, AO,          32'h0,         8'd4}, // R4
    '{1'b1, 5'h02, 2'd0, 32'hFF,        AO, 26'h0,       32'h0,         8'd7}, // R7
    '{1'b0, 5'h00, 2'd2, 32'h0,         AO, 26'h0,       32'h0000_3B00, 8'd7}, // R7
    '{1'b0, 5'h00, 2'd3, 32'h0,         AO, 26'h0,       32'h0,         8'd9}  // R9 size 3
  };

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        mrst_n = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [25:0] pin_dir = '0;
  logic [25:0] pin_in = '0;
  logic [25:0] pin_out;
  logic [25:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_port_regs dut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_dir(pin_dir), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [4:0] a, input logic [1:0] s,
                     input logic [31:0] d, output logic [31:0] r, output logic v);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid;
    r = rsp_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic        v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk(pin_out == 26'h0, "R5 reset pin_out", {6'h0, pin_out}, 32'h0);
    chk(pin_oe == 26'h0, "R1 reset pin_oe", {6'h0, pin_oe}, 32'h0);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 reset handshake",
        {30'h0, rsp_valid, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      pin_dir = VECS[i].dir;
      pin_in  = VECS[i].pins;
      repeat (3) @(negedge clk);
      acc(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, r, v);
      chk(v == 1'b1, $sformatf("R10 rsp_valid vec %0d", i), {31'h0, v}, 32'h1);
      chk(r == VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].req, i), r, VECS[i].exp);
    end

    // R3 synchronizer window: reads at E1, E2 old; at E3 new
    pin_dir = AI; pin_in = 26'h0;
    repeat (3) @(negedge clk);
    pin_in = 26'h1;
    acc(1'b0, 5'h02, 2'd1, 32'h0, r, v);
    chk(r == 32'h0, "R3 sync E1", r, 32'h0);
    acc(1'b0, 5'h02, 2'd1, 32'h0, r, v);
    chk(r == 32'h0, "R3 sync E2", r, 32'h0);
    acc(1'b0, 5'h02, 2'd1, 32'h0, r, v);
    chk(r == 32'h1, "R3 sync E3", r, 32'h1);

    // R1 pin_out and pin_oe
    pin_dir = AO;
    acc(1'b1, 5'h00, 2'd2, 32'h0000_0F0F, r, v);
    chk(pin_out == 26'h0000B0F, "R1 pin_out", {6'h0, pin_out}, 32'h0000_0B0F);
    chk(pin_oe == 26'h3FF3BFF, "R7 pin_oe holes", {6'h0, pin_oe}, 32'h03FF_3BFF);
    pin_dir = 26'h00000F0;
    #1;
    chk(pin_oe == 26'h00000F0, "R4 pin_oe input pins", {6'h0, pin_oe}, 32'h0000_00F0);

    // R5 manual reset keeps latch
    pin_dir = AO;
    @(negedge clk);
    acc(1'b1, 5'h00, 2'd2, 32'h0055_1234, r, v);
    mrst_n = 1'b0;
    #1;
    chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R5 mrst handshake",
        {30'h0, req_ready, rsp_valid}, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h00; req_size = 2'd2; req_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(pin_out == 26'h0551234, "R5 mrst pin_out", {6'h0, pin_out}, 32'h0055_1234);
    chk(rsp_valid == 1'b0, "R10 no rsp in mrst", {31'h0, rsp_valid}, 32'h0);
    mrst_n = 1'b1;
    @(negedge clk);
    acc(1'b0, 5'h00, 2'd2, 32'h0, r, v);
    chk(r == 32'h0055_1234, "R5 latch after mrst", r, 32'h0055_1234);

    // R10 back-pressure
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h00; req_size = 2'd2; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !req_ready && rsp_rdata == 32'h0055_1234, "R10 stall cycle 1",
        rsp_rdata, 32'h0055_1234);
    repeat (2) @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_rdata == 32'h0055_1234, "R10 stall cycle 3",
        rsp_rdata, 32'h0055_1234);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 drain",
        {30'h0, rsp_valid, req_ready}, 32'h1);

    // R5 power-on reset restores init
    por_n = 1'b0;
    @(negedge clk);
    chk(pin_out == 26'h0, "R5 por pin_out", {6'h0, pin_out}, 32'h0);
    por_n = 1'b1;
    @(negedge clk);
    acc(1'b0, 5'h00, 2'd2, 32'h0, r, v);
    chk(r == 32'h0, "R5 por read", r, 32'h0);

    finish_run();
  end
endmodule